// File: doc/BRIEF.md
# Half-word to word register access bridge

This block connects a host bus that issues 16-bit reads and writes to a register file that only takes whole 32-bit accesses. The host offset is reduced to the low 8 bits, and the 32-bit target is that offset rounded down to a 4-byte boundary.

Two half-word writes are collected in holding registers and then sent out as one 32-bit write. A half-word read starts one 32-bit read and keeps the result. The other half is then served from that kept copy, with no second downstream read. Each direction has its own pairing counter, and that counter restarts when the aligned address changes.

Byte-sized and reserved-size accesses are rejected with an error pulse. Full 32-bit accesses go straight through to the register file.

Top module: `hw16_reg_bridge`

## Requirements
- R1: Only `host_addr_i[7:0]` is decoded. A strobe to the register file carries `reg_addr_o` = `{host_addr_i[7:2], 2'b00}` of the access that caused it.
- R2: Size codes on `host_size_i` are: 2'b01 = 16-bit and 2'b10 = 32-bit. For a 16-bit write, `host_wdata_i[15:0]` goes to the high holding half when offset bit 1 is set, and to the low holding half otherwise. The second 16-bit write to the same aligned address gives a one-cycle `reg_we_o` in the next cycle, with `reg_wdata_o = {high, low}`.
- R3: A 16-bit write to a different aligned address than the previous 16-bit write clears the write pairing. That write counts as the first of a new pair and issues no strobe.
- R4: Pairing counts accesses, not halves. Two 16-bit writes to the same half of one aligned address also issue the 32-bit write. The other half carries its last held value.
- R5: The read counter is incremented on each 16-bit read. When it becomes one, a one-cycle `reg_re_o` follows in the next cycle and the returned word is kept. Otherwise the counter clears, no strobe is issued, and the kept word is used even if the register file has changed.
- R6: A 16-bit read to a different aligned address than the previous 16-bit read restarts read pairing and issues a new downstream read.
- R7: A 16-bit read response appears two cycles after the request, with `host_rvalid_o` high for one cycle. `host_rdata_o` holds bits 31:16 of the word when offset bit 1 is set, bits 15:0 otherwise, and zero in bits 31:16.
- R8: A byte access (size 2'b00) or reserved access (2'b11) gives a one-cycle `host_err_o` in the next cycle. It issues no strobe and leaves the pairing state unchanged.
- R9: A 32-bit write issues `reg_we_o` next cycle with `reg_wdata_o = host_wdata_i`. A 32-bit read issues `reg_re_o` next cycle and returns the full word two cycles after the request. Neither one disturbs the 16-bit pairing counters or holding registers.
- R10: Reset clears both pairing counters, both stored aligned addresses, the holding halves and the kept read word, and holds all strobes, `host_err_o` and `host_rvalid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access valid for this cycle |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_size_i | input | 2 | Access size code |
| host_addr_i | input | ADDR_W | Host byte offset |
| host_wdata_i | input | DATA_W | Write data (16-bit writes use the low half) |
| host_rvalid_o | output | 1 | Read response valid |
| host_rdata_o | output | DATA_W | Read response data |
| host_err_o | output | 1 | Bad-size access pulse |
| reg_we_o | output | 1 | 32-bit write strobe |
| reg_re_o | output | 1 | 32-bit read strobe |
| reg_addr_o | output | OFFS_W | Aligned register address |
| reg_wdata_o | output | DATA_W | 32-bit write data |
| reg_rdata_i | input | DATA_W | Register file read data, valid while `reg_re_o` is high |

## Verification
The properties take for granted that the host presents at most one access per cycle. They also assume the register file returns `reg_rdata_i` in the same cycle as `reg_re_o`. The bench drives one access and then waits a cycle before the next, so responses never overlap. Its register model is combinational on `reg_addr_o`. Random offsets come from four aligned words with random upper address bits. This makes pairs, restarts and same-half repeats occur often.

// File: rtl/hwb_pkg.sv
`timescale 1ns/1ps
package hwb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/hwb_wr_pack.sv
`timescale 1ns/1ps
module hwb_wr_pack #(
  parameter int OFFS_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_we_i,
  input  logic [OFFS_W-1:0] word_addr_i,
  input  logic              hi_sel_i,
  input  logic [DATA_W/2-1:0] hw_data_i,
  output logic              fire_o,
  output logic [DATA_W-1:0] fire_data_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PAIR_N = DATA_W / HALF_W;
  localparam int CNT_W  = $clog2(PAIR_N + 1);

  logic [OFFS_W-1:0] prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_inc;
  logic [HALF_W-1:0] lo_q, hi_q, lo_n, hi_n;

  always_comb begin
    cnt_base    = (word_addr_i == prev_q) ? cnt_q : '0;
    cnt_inc     = cnt_base + CNT_W'(1);
    lo_n        = hi_sel_i ? lo_q : hw_data_i;
    hi_n        = hi_sel_i ? hw_data_i : hi_q;
    fire_o      = hw_we_i && (cnt_inc == CNT_W'(PAIR_N));
    fire_data_o = {hi_n, lo_n};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (hw_we_i) begin
      prev_q <= word_addr_i;
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      cnt_q  <= fire_o ? '0 : cnt_inc;
    end
  end
endmodule

// File: rtl/hwb_rd_split.sv
`timescale 1ns/1ps
module hwb_rd_split #(
  parameter int OFFS_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_re_i,
  input  logic [OFFS_W-1:0] word_addr_i,
  input  logic              hi_sel_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              issue_o,
  output logic              rsp_valid_o,
  output logic [DATA_W/2-1:0] rsp_data_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = 2;

  logic [OFFS_W-1:0] prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_inc;
  logic              pend_q, hi_q, fresh_q;
  logic [DATA_W-1:0] long_q, src;
  logic              rsp_valid_q;
  logic [HALF_W-1:0] rsp_data_q;

  always_comb begin
    cnt_base = (word_addr_i == prev_q) ? cnt_q : '0;
    cnt_inc  = cnt_base + CNT_W'(1);
    issue_o  = hw_re_i && (cnt_inc == CNT_W'(1));
    src      = fresh_q ? rd_data_i : long_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else if (hw_re_i) begin
      prev_q <= word_addr_i;
      cnt_q  <= (cnt_inc == CNT_W'(1)) ? cnt_inc : '0;
    end
  end

  // stage 1: strobe out; stage 2: capture and select half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      hi_q        <= 1'b0;
      fresh_q     <= 1'b0;
      long_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      pend_q      <= hw_re_i;
      fresh_q     <= issue_o;
      if (hw_re_i) hi_q <= hi_sel_i;
      if (pend_q && fresh_q) long_q <= rd_data_i;
      rsp_valid_q <= pend_q;
      if (pend_q) rsp_data_q <= hi_q ? src[DATA_W-1:HALF_W] : src[HALF_W-1:0];
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/hw16_reg_bridge.sv
`timescale 1ns/1ps
module hw16_reg_bridge #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [1:0]        host_size_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              host_rvalid_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_err_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [OFFS_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  import hwb_pkg::*;

  localparam int HALF_W   = DATA_W / 2;
  localparam int LANE_LSB = $clog2(DATA_W / 8);
  localparam int HSEL_BIT = LANE_LSB - 1;

  acc_size_e         size;
  logic [OFFS_W-1:0] off, word_addr;
  logic              hi_sel, is_half, is_word, is_bad;
  logic              hw_we, hw_re, wd_we, wd_re;
  logic              wr_fire, rd_issue;
  logic [DATA_W-1:0] fire_data;
  logic              half_rsp_valid;
  logic [HALF_W-1:0] half_rsp_data;

  logic              reg_we_q, reg_re_q, err_q;
  logic [OFFS_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wd_pend_q, wd_rsp_valid_q;
  logic [DATA_W-1:0] wd_rsp_data_q;

  always_comb begin
    size      = acc_size_e'(host_size_i);
    off       = host_addr_i[OFFS_W-1:0];
    word_addr = {off[OFFS_W-1:LANE_LSB], LANE_LSB'(0)};
    hi_sel    = off[HSEL_BIT];
    is_half   = host_req_i && (size == SZ_HALF);
    is_word   = host_req_i && (size == SZ_WORD);
    is_bad    = host_req_i && (size == SZ_BYTE || size == SZ_RSVD);
    hw_we     = is_half && host_we_i;
    hw_re     = is_half && !host_we_i;
    wd_we     = is_word && host_we_i;
    wd_re     = is_word && !host_we_i;
  end

  hwb_wr_pack #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hw_we_i     (hw_we),
    .word_addr_i (word_addr),
    .hi_sel_i    (hi_sel),
    .hw_data_i   (host_wdata_i[HALF_W-1:0]),
    .fire_o      (wr_fire),
    .fire_data_o (fire_data)
  );

  hwb_rd_split #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hw_re_i     (hw_re),
    .word_addr_i (word_addr),
    .hi_sel_i    (hi_sel),
    .rd_data_i   (reg_rdata_i),
    .issue_o     (rd_issue),
    .rsp_valid_o (half_rsp_valid),
    .rsp_data_o  (half_rsp_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_we_q <= 1'b0;
      reg_re_q <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      reg_we_q <= wd_we || wr_fire;
      reg_re_q <= wd_re || rd_issue;
      err_q    <= is_bad;
      if (wd_we || wr_fire || wd_re || rd_issue) addr_q <= word_addr;
      if (wd_we)        wdata_q <= host_wdata_i;
      else if (wr_fire) wdata_q <= fire_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_pend_q      <= 1'b0;
      wd_rsp_valid_q <= 1'b0;
      wd_rsp_data_q  <= '0;
    end else begin
      wd_pend_q      <= wd_re;
      wd_rsp_valid_q <= wd_pend_q;
      if (wd_pend_q) wd_rsp_data_q <= reg_rdata_i;
    end
  end

  assign reg_we_o      = reg_we_q;
  assign reg_re_o      = reg_re_q;
  assign reg_addr_o    = addr_q;
  assign reg_wdata_o   = wdata_q;
  assign host_err_o    = err_q;
  assign host_rvalid_o = wd_rsp_valid_q || half_rsp_valid;
  assign host_rdata_o  = wd_rsp_valid_q ? wd_rsp_data_q
                                        : {{(DATA_W-HALF_W){1'b0}}, half_rsp_data};
endmodule

// File: rtl/hwb_checker.sv
`timescale 1ns/1ps
module hwb_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_req_i,
  input logic              host_we_i,
  input logic [1:0]        host_size_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic              host_rvalid_o,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              host_err_o,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic [OFFS_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic [DATA_W-1:0] reg_rdata_i
);
  logic bad_sz, word_sz, half_sz;
  assign bad_sz  = host_req_i && (host_size_i == 2'b00 || host_size_i == 2'b11);
  assign word_sz = host_req_i && (host_size_i == 2'b10);
  assign half_sz = host_req_i && (host_size_i == 2'b01);

  p_bad_size_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_sz |=> (host_err_o && !reg_we_o && !reg_re_o));

  p_good_size_no_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_sz || half_sz) |=> !host_err_o);

  p_word_wr_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_sz && host_we_i) |=> (reg_we_o && reg_wdata_o == $past(host_wdata_i)));

  p_word_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_sz |=> (reg_addr_o == {$past(host_addr_i[OFFS_W-1:2]), 2'b00}));

  p_half_rd_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_sz && !host_we_i) |=> ##1 host_rvalid_o);

  p_strobe_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o}));
endmodule

bind hw16_reg_bridge hwb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W)
) u_chk (.*);

// File: tb/sim_hw16_reg_bridge.sv
`timescale 1ns/1ps
module sim_hw16_reg_bridge;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int OFFS_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              host_req_i = 1'b0;
  logic              host_we_i = 1'b0;
  logic [1:0]        host_size_i = 2'b00;
  logic [ADDR_W-1:0] host_addr_i = '0;
  logic [DATA_W-1:0] host_wdata_i = '0;
  logic              host_rvalid_o, host_err_o, reg_we_o, reg_re_o;
  logic [DATA_W-1:0] host_rdata_o, reg_wdata_o, reg_rdata_i;
  logic [OFFS_W-1:0] reg_addr_o;

  logic [31:0] mem [64];
  int checks = 0, fails = 0;
  bit done = 0;

  // bench reference state
  logic [7:0]  m_wprev, m_rprev;
  int          m_wn, m_rn;
  logic [15:0] m_wl, m_wh;
  logic [31:0] m_rlong;

  always #5 clk_i = ~clk_i;

  hw16_reg_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W)) u0 (.*);

  assign reg_rdata_i = mem[reg_addr_o[7:2]];
  always @(posedge clk_i) if (reg_we_o) mem[reg_addr_o[7:2]] <= reg_wdata_o;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_wprev = '0; m_rprev = '0; m_wn = 0; m_rn = 0;
    m_wl = '0; m_wh = '0; m_rlong = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; host_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    model_reset();
    chk(!reg_we_o && !reg_re_o, "R10 strobes in reset", {reg_we_o, reg_re_o}, 0);
    chk(!host_err_o && !host_rvalid_o, "R10 err/rvalid in reset", {host_err_o, host_rvalid_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic acc(bit we, logic [1:0] sz, logic [15:0] addr, logic [31:0] wd, string tag);
    logic [7:0]  wa;
    bit          hi, e_we, e_re, e_err, e_rv;
    logic [31:0] e_wd, e_rd;
    wa = {addr[7:2], 2'b00};
    hi = addr[1];
    e_we = 0; e_re = 0; e_err = 0; e_rv = 0; e_wd = '0; e_rd = '0;
    if (sz == 2'b00 || sz == 2'b11) e_err = 1;
    else if (sz == 2'b10) begin
      if (we) begin e_we = 1; e_wd = wd; end
      else begin e_re = 1; e_rv = 1; e_rd = mem[wa[7:2]]; end
    end else if (we) begin
      if (wa != m_wprev) begin m_wn = 0; m_wprev = wa; end
      if (hi) m_wh = wd[15:0]; else m_wl = wd[15:0];
      m_wn++;
      if (m_wn == 2) begin m_wn = 0; e_we = 1; e_wd = {m_wh, m_wl}; end
    end else begin
      if (wa != m_rprev) begin m_rn = 0; m_rprev = wa; end
      m_rn++;
      if (m_rn == 1) begin e_re = 1; m_rlong = mem[wa[7:2]]; end
      else m_rn = 0;
      e_rv = 1;
      e_rd = {16'h0, hi ? m_rlong[31:16] : m_rlong[15:0]};
    end
    @(negedge clk_i);
    host_req_i = 1'b1; host_we_i = we; host_size_i = sz;
    host_addr_i = addr; host_wdata_i = wd;
    @(negedge clk_i);
    host_req_i = 1'b0;
    chk(host_err_o == e_err, {tag, " err R8"}, 32'(host_err_o), 32'(e_err));
    chk(reg_we_o == e_we, {tag, " write strobe R2"}, 32'(reg_we_o), 32'(e_we));
    chk(reg_re_o == e_re, {tag, " read strobe R5"}, 32'(reg_re_o), 32'(e_re));
    if (e_we || e_re)
      chk(reg_addr_o == wa, {tag, " aligned addr R1"}, 32'(reg_addr_o), 32'(wa));
    if (e_we)
      chk(reg_wdata_o == e_wd, {tag, " write data R2"}, reg_wdata_o, e_wd);
    chk(!host_rvalid_o, {tag, " early rvalid R7"}, 32'(host_rvalid_o), 0);
    @(negedge clk_i);
    chk(host_rvalid_o == e_rv, {tag, " rvalid R7"}, 32'(host_rvalid_o), 32'(e_rv));
    if (e_rv)
      chk(host_rdata_o == e_rd, {tag, " rdata R7"}, host_rdata_o, e_rd);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5000000 ^ (i * 32'h01030507);
    do_reset();
    // R2 pairing, low then high
    acc(1, 2'b01, 16'h0010, 32'h0000_1111, "R2 lo");
    acc(1, 2'b01, 16'h0012, 32'h0000_2222, "R2 hi");
    acc(0, 2'b10, 16'h0010, 32'h0, "R2 readback");
    // R1 upper bits ignored
    acc(1, 2'b01, 16'hAB16, 32'h0000_3333, "R1 hi");
    acc(1, 2'b01, 16'h5514, 32'h0000_4444, "R1 lo");
    // R3 address change restarts
    acc(1, 2'b01, 16'h0020, 32'h0000_5555, "R3 first");
    acc(1, 2'b01, 16'h0026, 32'h0000_6666, "R3 moved");
    acc(1, 2'b01, 16'h0024, 32'h0000_7777, "R3 pair");
    // R4 same half twice
    acc(1, 2'b01, 16'h0030, 32'h0000_8888, "R4 a");
    acc(1, 2'b01, 16'h0030, 32'h0000_9999, "R4 b");
    // R5 reuse of kept word
    acc(0, 2'b01, 16'h0010, 32'h0, "R5 first");
    mem[4] = 32'hDEAD_BEEF;
    acc(0, 2'b01, 16'h0012, 32'h0, "R5 stale");
    acc(0, 2'b01, 16'h0010, 32'h0, "R5 fresh");
    // R6 read address change
    acc(0, 2'b01, 16'h0022, 32'h0, "R6 to 0x20");
    acc(0, 2'b01, 16'h0042, 32'h0, "R6 to 0x40");
    // R8 bad sizes do not disturb pairing
    acc(1, 2'b01, 16'h0040, 32'h0000_AAAA, "R8 lo");
    acc(1, 2'b00, 16'h0041, 32'h0000_00FF, "R8 byte wr");
    acc(0, 2'b11, 16'h0040, 32'h0, "R8 rsvd rd");
    acc(1, 2'b01, 16'h0042, 32'h0000_BBBB, "R8 hi");
    // R9 word accesses leave pairing alone
    acc(1, 2'b01, 16'h0050, 32'h0000_CCCC, "R9 lo");
    acc(1, 2'b10, 16'h0053, 32'h1234_5678, "R9 word wr");
    acc(1, 2'b01, 16'h0052, 32'h0000_DDDD, "R9 hi");
    acc(0, 2'b01, 16'h0050, 32'h0, "R9 half rd");
    mem[20] = 32'h0BAD_F00D;
    acc(0, 2'b10, 16'h0050, 32'h0, "R9 word rd");
    acc(0, 2'b01, 16'h0052, 32'h0, "R9 half rd2");
    // R10 reset mid-pair
    acc(1, 2'b01, 16'h0060, 32'h0000_EEEE, "R10 lo");
    do_reset();
    acc(1, 2'b01, 16'h0062, 32'h0000_F0F0, "R10 after");
    acc(1, 2'b01, 16'h0062, 32'h0000_0F0F, "R10 pair");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0]  sz;
      logic [15:0] a;
      int          r;
      r  = int'($urandom_range(0, 9));
      sz = (r < 6) ? 2'b01 : (r < 8) ? 2'b10 : (r == 8) ? 2'b00 : 2'b11;
      a  = {8'($urandom), 4'h0, 2'($urandom), 1'($urandom), 1'($urandom)};
      acc(1'($urandom), sz, a, $urandom, "rand");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule